// File: doc/BRIEF.md
# Scanline Display Timing Generator

This block produces the raster timing for a 240 by 160 pixel display. A free-running cycle counter divides each scanline into a visible portion of 960 clocks and a horizontal blank of 272 clocks, for 1232 clocks in all. A line counter steps through 228 lines per frame. Lines 0 to 159 carry picture and lines 160 to 227 form the vertical blank.

From these two counters the block keeps two status flags, one for horizontal blank and one for vertical blank. It raises one-cycle interrupt requests when the matching enable input is high. It also raises one-cycle trigger strobes that a DMA engine can use to start a transfer at the beginning of each horizontal blank and at the beginning of the vertical blank.

Every output is registered. The geometry is set by parameters, and their default values give the figures above.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the line number is 0, both flags are low, and all four pulse outputs are low. Timing then starts at cycle 0 of line 0, in the visible portion.
- R2: Counting from the first clock edge of a line as cycle 1, the horizontal-blank flag rises on edge 960 (DRAW_CYC) of that line. It stays high for the remaining 272 (BLANK_CYC) cycles.
- R3: The line number increments on the edge that closes a line (1232 cycles per line). It wraps from 227 (TOTAL_LINES-1) to 0 and holds its value at every other edge.
- R4: The horizontal-blank flag falls on the same edge on which the line number advances.
- R5: `hblank_irq` is high for exactly the one cycle in which the horizontal-blank flag has just risen. It does so only if `hblank_irq_en` was high at that edge.
- R6: `hblank_dma` pulses for one cycle at every horizontal-blank start, whatever the enables are. This includes lines of the vertical blank.
- R7: The vertical-blank flag goes high on entering line 160 (VIS_LINES). It goes low on entering line 227, so it reads high only on lines 160 to 226.
- R8: `vblank_irq` pulses for one cycle on entering line 160, only if `vblank_irq_en` was high at that edge.
- R9: `vblank_dma` pulses for one cycle on entering line 160, regardless of the enables.
- R10: A frame lasts TOTAL_LINES × (DRAW_CYC + BLANK_CYC) cycles, 280896 by default. The whole pattern then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank_irq_en | input | 1 | Allow the horizontal-blank interrupt pulse |
| vblank_irq_en | input | 1 | Allow the vertical-blank interrupt pulse |
| line_num | output | $clog2(TOTAL_LINES) | Current scanline number |
| hblank_flag | output | 1 | High during horizontal blank |
| vblank_flag | output | 1 | High on lines VIS_LINES to TOTAL_LINES-2 |
| hblank_irq | output | 1 | One-cycle horizontal-blank interrupt request |
| vblank_irq | output | 1 | One-cycle vertical-blank interrupt request |
| hblank_dma | output | 1 | One-cycle horizontal-blank DMA trigger |
| vblank_dma | output | 1 | One-cycle vertical-blank DMA trigger |

## Verification
The bench targets several off-by-one corners:
- The exact edge of the blank start. A counter compared one value early or late shifts every flag and pulse by a cycle.
- The wrap from the last line back to 0. A wrong modulus lets the line number run past 227 or drop a line.
- The early clear of the vertical-blank flag on line 227. A design that clears it on the wrap to 0 keeps the flag high for one extra line.
- The masking of the interrupts. The bench toggles the enables at random, and a design that ties the DMA strobes to the enables, or ignores an enable, gets caught.

A reduced-geometry copy runs many full frames so that the vertical-blank entry, exit and frame wrap are each crossed several times. A reset is also applied in mid-line.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned DEF_DRAW_CYC    = 960;
  localparam int unsigned DEF_BLANK_CYC   = 272;
  localparam int unsigned DEF_VIS_LINES   = 160;
  localparam int unsigned DEF_TOTAL_LINES = 228;

  typedef enum logic {
    PH_DRAW  = 1'b0,
    PH_BLANK = 1'b1
  } hphase_e;
endpackage

// File: rtl/scan_hcount.sv
module scan_hcount #(
  parameter int unsigned DRAW_CYC  = scan_pkg::DEF_DRAW_CYC,
  parameter int unsigned BLANK_CYC = scan_pkg::DEF_BLANK_CYC
) (
  input  logic clk,
  input  logic rst_n,
  output logic draw_end,
  output logic line_end
);
  localparam int unsigned LINE_CYC = DRAW_CYC + BLANK_CYC;
  localparam int unsigned HW       = $clog2(LINE_CYC);

  logic [HW-1:0] hpos_q, hpos_d;

  always_comb begin
    draw_end = (hpos_q == HW'(DRAW_CYC - 1));
    line_end = (hpos_q == HW'(LINE_CYC - 1));
    hpos_d   = line_end ? '0 : hpos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpos_q <= '0;
    else        hpos_q <= hpos_d;
  end

  p_hpos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hpos_q < HW'(LINE_CYC));
  p_line_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hpos_q == '0);
endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
  parameter int unsigned TOTAL_LINES = scan_pkg::DEF_TOTAL_LINES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_end,
  output logic [$clog2(TOTAL_LINES)-1:0] line_q,
  output logic [$clog2(TOTAL_LINES)-1:0] line_next
);
  localparam int unsigned LW = $clog2(TOTAL_LINES);

  logic at_last;

  always_comb begin
    at_last   = (line_q == LW'(TOTAL_LINES - 1));
    line_next = line_q;
    if (line_end) line_next = at_last ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_q <= '0;
    else if (line_end) line_q <= line_next;
  end

  p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < LW'(TOTAL_LINES));
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line_q));
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && at_last) |=> line_q == '0);
endmodule

// File: rtl/scan_events.sv
module scan_events #(
  parameter int unsigned VIS_LINES   = scan_pkg::DEF_VIS_LINES,
  parameter int unsigned TOTAL_LINES = scan_pkg::DEF_TOTAL_LINES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           draw_end,
  input  logic                           line_end,
  input  logic [$clog2(TOTAL_LINES)-1:0] line_q,
  input  logic [$clog2(TOTAL_LINES)-1:0] line_next,
  input  logic                           hblank_irq_en,
  input  logic                           vblank_irq_en,
  output logic                           hblank_flag,
  output logic                           vblank_flag,
  output logic                           hblank_irq,
  output logic                           vblank_irq,
  output logic                           hblank_dma,
  output logic                           vblank_dma
);
  import scan_pkg::*;
  localparam int unsigned LW = $clog2(TOTAL_LINES);

  hphase_e phase_q, phase_d;
  logic    vflag_d, hirq_d, virq_d, hdma_d, vdma_d;
  logic    enter_vblank, leave_vblank;

  always_comb begin
    enter_vblank = line_end && (line_next == LW'(VIS_LINES));
    leave_vblank = line_end && (line_next == LW'(TOTAL_LINES - 1));

    phase_d = phase_q;
    if (draw_end)      phase_d = PH_BLANK;
    else if (line_end) phase_d = PH_DRAW;

    vflag_d = vblank_flag;
    if (enter_vblank)      vflag_d = 1'b1;
    else if (leave_vblank) vflag_d = 1'b0;

    hdma_d = draw_end;
    hirq_d = draw_end && hblank_irq_en;
    vdma_d = enter_vblank;
    virq_d = enter_vblank && vblank_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_DRAW;
      vblank_flag <= 1'b0;
      hblank_irq  <= 1'b0;
      vblank_irq  <= 1'b0;
      hblank_dma  <= 1'b0;
      vblank_dma  <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      vblank_flag <= vflag_d;
      hblank_irq  <= hirq_d;
      vblank_irq  <= virq_d;
      hblank_dma  <= hdma_d;
      vblank_dma  <= vdma_d;
    end
  end

  assign hblank_flag = (phase_q == PH_BLANK);

  p_hflag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hblank_flag) |-> hblank_dma);
  p_hflag_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hblank_flag) |-> line_q != $past(line_q));
  p_hirq_in_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_irq |-> hblank_dma);
  p_hdma_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_dma |=> !hblank_dma);
  p_vflag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank_flag) |-> line_q == LW'(VIS_LINES));
  p_vflag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank_flag) |-> line_q == LW'(TOTAL_LINES - 1));
  p_virq_in_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> vblank_dma);
  p_vdma_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_dma |=> !vblank_dma);
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int unsigned DRAW_CYC    = scan_pkg::DEF_DRAW_CYC,
  parameter int unsigned BLANK_CYC   = scan_pkg::DEF_BLANK_CYC,
  parameter int unsigned VIS_LINES   = scan_pkg::DEF_VIS_LINES,
  parameter int unsigned TOTAL_LINES = scan_pkg::DEF_TOTAL_LINES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hblank_irq_en,
  input  logic                           vblank_irq_en,
  output logic [$clog2(TOTAL_LINES)-1:0] line_num,
  output logic                           hblank_flag,
  output logic                           vblank_flag,
  output logic                           hblank_irq,
  output logic                           vblank_irq,
  output logic                           hblank_dma,
  output logic                           vblank_dma
);
  localparam int unsigned LW = $clog2(TOTAL_LINES);

  logic          draw_end, line_end;
  logic [LW-1:0] line_next;

  scan_hcount #(.DRAW_CYC(DRAW_CYC), .BLANK_CYC(BLANK_CYC)) u_hcount (
    .clk      (clk),
    .rst_n    (rst_n),
    .draw_end (draw_end),
    .line_end (line_end)
  );

  scan_vcount #(.TOTAL_LINES(TOTAL_LINES)) u_vcount (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .line_q    (line_num),
    .line_next (line_next)
  );

  scan_events #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)) u_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .draw_end      (draw_end),
    .line_end      (line_end),
    .line_q        (line_num),
    .line_next     (line_next),
    .hblank_irq_en (hblank_irq_en),
    .vblank_irq_en (vblank_irq_en),
    .hblank_flag   (hblank_flag),
    .vblank_flag   (vblank_flag),
    .hblank_irq    (hblank_irq),
    .vblank_irq    (vblank_irq),
    .hblank_dma    (hblank_dma),
    .vblank_dma    (vblank_dma)
  );
endmodule

// File: tb/tb_scan_timing_gen.sv
module tb_scan_timing_gen;
  localparam int S_DRAW = 12, S_BLANK = 5, S_VIS = 10, S_TOTAL = 14;
  localparam int RUN_CYC = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hen = 1'b0, ven = 1'b0;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  logic [7:0] d_line;
  logic d_hf, d_vf, d_hi, d_vi, d_hd, d_vd;
  logic [3:0] s_line;
  logic s_hf, s_vf, s_hi, s_vi, s_hd, s_vd;

  always #5 clk = ~clk;

  scan_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .hblank_irq_en(hen), .vblank_irq_en(ven),
    .line_num(d_line), .hblank_flag(d_hf), .vblank_flag(d_vf),
    .hblank_irq(d_hi), .vblank_irq(d_vi), .hblank_dma(d_hd), .vblank_dma(d_vd));

  scan_timing_gen #(.DRAW_CYC(S_DRAW), .BLANK_CYC(S_BLANK),
                    .VIS_LINES(S_VIS), .TOTAL_LINES(S_TOTAL)) dut_small (
    .clk(clk), .rst_n(rst_n), .hblank_irq_en(hen), .vblank_irq_en(ven),
    .line_num(s_line), .hblank_flag(s_hf), .vblank_flag(s_vf),
    .hblank_irq(s_hi), .vblank_irq(s_vi), .hblank_dma(s_hd), .vblank_dma(s_vd));

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // n = edges since reset release; he/ve = enables present at the last edge
  task automatic check_geom(input string tag, input int n, input int dr, input int bl,
                            input int vis, input int tot, input bit he, input bit ve,
                            input int line, input bit hf, input bit vf, input bit hi,
                            input bit vi, input bit hd, input bit vd);
    int lc, p, l;
    bit hstart, vstart;
    lc = dr + bl;
    p  = n % lc;
    l  = (n / lc) % tot;
    hstart = (n > 0) && (p == dr);
    vstart = (n > 0) && (p == 0) && (l == vis);
    chk("R3",  {tag, " line"}, line, l);
    chk("R2",  {tag, " hblank_flag"}, int'(hf), int'(p >= dr));
    chk("R7",  {tag, " vblank_flag"}, int'(vf), int'(l >= vis && l < tot - 1));
    chk("R5",  {tag, " hblank_irq"}, int'(hi), int'(hstart && he));
    chk("R6",  {tag, " hblank_dma"}, int'(hd), int'(hstart));
    chk("R8",  {tag, " vblank_irq"}, int'(vi), int'(vstart && ve));
    chk("R9",  {tag, " vblank_dma"}, int'(vd), int'(vstart));
  endtask

  initial begin
    int n;
    bit he_e, ve_e;
    int frames_seen;
    void'($urandom(32'h5CA1_1E00));
    n = 0; he_e = 0; ve_e = 0; frames_seen = 0;
    // R1: reset state
    #1;
    @(negedge clk);
    chk("R1", "line in reset", int'(d_line), 0);
    chk("R1", "flags in reset", int'({d_hf, d_vf, d_hi, d_vi, d_hd, d_vd}), 0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN_CYC; c++) begin
      hen = ($urandom % 3) != 0;
      ven = (c % 600) < 300 ? 1'b1 : ($urandom % 2);
      if (c == 2500) rst_n = 1'b0;      // mid-line reset
      if (c == 2503) rst_n = 1'b1;
      he_e = hen; ve_e = ven;
      @(posedge clk);
      if (rst_n) n++; else n = 0;
      @(negedge clk);
      check_geom("default", n, 960, 272, 160, 228, he_e, ve_e, int'(d_line),
                 d_hf, d_vf, d_hi, d_vi, d_hd, d_vd);
      check_geom("small", n, S_DRAW, S_BLANK, S_VIS, S_TOTAL, he_e, ve_e, int'(s_line),
                 s_hf, s_vf, s_hi, s_vi, s_hd, s_vd);
      // R10 / R4: frame boundary of the reduced copy
      if (n > 0 && n % (S_TOTAL * (S_DRAW + S_BLANK)) == 0) begin
        frames_seen++;
        chk("R10", "small frame wrap line", int'(s_line), 0);
        chk("R4", "hblank cleared at line start", int'(s_hf), 0);
      end
      if (c == 2501) chk("R1", "line after async reset", int'(d_line), 0);
    end
    chk("R10", "small frames completed", int'(frames_seen > 3), 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (RUN_CYC * 2 + 100) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule